// File: doc/BRIEF.md
# Reconfigurable Distributed-Arithmetic FIR Filter

This block is a four-tap FIR filter built without multipliers. Each accepted input sample enters a short delay line. The filter then walks through the bit positions of the stored samples, least significant first. At each position it collects the bit of every tap into a table address. The table holds every possible sum of a subset of the coefficients, so the addressed entry is that bit position's share of the inner product. A scaling accumulator shifts each entry by its bit weight and adds it in. The entry for the sign bit is subtracted instead of added, because samples are two's complement. The final sum is the exact, full-precision result.

The partial-sum table is writable storage. When software writes one coefficient, the block recomputes all 2^TAPS entries in sequence, one entry per clock. While it does this, `busy` is high and no result is produced. The table has one storage array and `BPC` read ports on it. Each port serves one bit-slice unit, and the slice units handle different bit positions in the same cycle. With the default `BPC = 1`, one output takes eight cycles.

A result is produced only when a sample is accepted, and a sample is accepted only while the block is idle. The caller either watches `busy` or leaves enough time between samples.

Top module: `dafir_top`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_result` are 0, and all coefficients and stored samples are zero. The first result after reset is therefore 0.
- R2: A sample that is accepted while idle enters delay-line position 0 (the newest) and the oldest sample drops out. The result is sum over k = 0..3 of c_k * x[n-k], where x[n] is the newest sample and all operands are two's complement. The result is exact in the 18-bit `out_result`.
- R3: `out_valid` is a one-cycle pulse on the 8th rising edge after the accepting edge. `out_result` holds its value between pulses.
- R4: Negative samples and coefficients give exact results, including -128, because the sign bit slice is subtracted.
- R5: `in_valid` has no effect while the block is busy: the sample does not enter the delay line.
- R6: `coef_wr` while idle stores `coef_val` as coefficient c_k, with k given by `coef_idx` (0..3). The table rebuild then keeps `busy` high for 16 cycles after the write edge, and `out_valid` stays low during the rebuild.
- R7: `coef_wr` while a result is being computed is ignored.
- R8: `coef_wr` during a rebuild is accepted and restarts the full 16-cycle rebuild.
- R9: When `coef_wr` and `in_valid` are both high in the same idle cycle, the coefficient write is taken and the sample is dropped.
- R10: A coefficient reload leaves the delay line unchanged. The next result combines the new coefficients with the old sample history.
- R11: `busy` is high exactly from the edge after a sample or coefficient is accepted until the edge that completes the computation or the rebuild.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Offers `in_sample` for acceptance |
| in_sample | input | 8 | Two's-complement input sample |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_idx | input | 2 | Tap index k of the coefficient being written |
| coef_val | input | 8 | Two's-complement coefficient value |
| busy | output | 1 | High while computing or rebuilding the table |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 18 | Two's-complement filter output |

## Verification
The first pattern is sparse single samples with a mix of signed coefficients; it separates errors in tap ordering from errors in bit weighting. The second pattern uses the extreme values -128 and 127 on both operands, which exposes a sign slice that is added instead of subtracted, or a partial sum that is too narrow. The third pattern holds `in_valid` high continuously and places coefficient writes during computation, during rebuild and in the same cycle as a sample. These show whether each of the ignore and priority rules holds. A long pseudo-random stream, with occasional reloads in the middle, is then compared cycle by cycle against a behavioural multiply-accumulate model; this shows whether the history survives a table rebuild.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
  typedef enum logic [0:0] {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/dafir_taps.sv
module dafir_taps #(
  parameter int TAPS = 4,
  parameter int SW   = 8,
  parameter int BPC  = 1,
  localparam int STEPS = SW / BPC,
  localparam int SBW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [SW-1:0]             sample_in,
  input  logic [SBW-1:0]            step,
  output logic [BPC-1:0][TAPS-1:0]  slice_addr
);
  logic [TAPS-1:0][SW-1:0] tap_q;

  // Collect one bit position across all taps: the 2-D shift view.
  function automatic logic [TAPS-1:0] gather_bit(
    input logic [TAPS-1:0][SW-1:0] t, input int unsigned pos);
    logic [TAPS-1:0] a;
    for (int k = 0; k < TAPS; k++) a[k] = t[k][pos];
    return a;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else if (shift_en) tap_q <= {tap_q[TAPS-2:0], sample_in};
  end

  for (genvar j = 0; j < BPC; j++) begin : g_slice
    assign slice_addr[j] = gather_bit(tap_q, int'(step) * BPC + j);
  end
endmodule

// File: rtl/dafir_lut.sv
module dafir_lut #(
  parameter int TAPS = 4,
  parameter int CW   = 8,
  parameter int BPC  = 1,
  localparam int ENTRIES = 1 << TAPS,
  localparam int LW      = CW + $clog2(TAPS),
  localparam int TIW     = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      coef_we,
  input  logic [TIW-1:0]            coef_sel,
  input  logic [CW-1:0]             coef_data,
  input  logic [BPC-1:0][TAPS-1:0]  rd_addr,
  output logic [BPC-1:0][LW-1:0]    rd_data,
  output logic                      rebuild_busy
);
  logic [TAPS-1:0][CW-1:0] coef_q;
  logic [LW-1:0]           table_q [ENTRIES];
  logic [TAPS-1:0]         ptr_q;
  logic                    busy_q;
  logic                    tbl_wr;

  // Sum of the coefficients whose address bit is set.
  function automatic logic [LW-1:0] partial_sum(
    input logic [TAPS-1:0][CW-1:0] coefs, input logic [TAPS-1:0] addr);
    logic signed [LW-1:0] s;
    logic signed [CW-1:0] c;
    s = '0;
    for (int k = 0; k < TAPS; k++) begin
      c = coefs[k];
      if (addr[k]) s = s + LW'(c);
    end
    return s;
  endfunction

  assign tbl_wr       = busy_q && !coef_we;
  assign rebuild_busy = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coef_q <= '0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
      for (int e = 0; e < ENTRIES; e++) table_q[e] <= '0;
    end else if (coef_we) begin
      coef_q[coef_sel] <= coef_data;
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      table_q[ptr_q] <= partial_sum(coef_q, ptr_q);
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == TAPS'(ENTRIES - 1)) busy_q <= 1'b0;
    end
  end

  for (genvar j = 0; j < BPC; j++) begin : g_port
    assign rd_data[j] = table_q[rd_addr[j]];
  end

  AST_ENTRY0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    table_q[0] == '0); // R2
  AST_REBUILD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_wr && ptr_q == TAPS'(ENTRIES - 1)) |=> !busy_q); // R6
  AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> (busy_q && ptr_q == '0)); // R8
endmodule

// File: rtl/dafir_accum.sv
module dafir_accum #(
  parameter int TAPS = 4,
  parameter int CW   = 8,
  parameter int SW   = 8,
  parameter int BPC  = 1,
  localparam int LW    = CW + $clog2(TAPS),
  localparam int OW    = LW + SW,
  localparam int STEPS = SW / BPC,
  localparam int SBW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    last,
  input  logic [SBW-1:0]          step,
  input  logic [BPC-1:0][LW-1:0]  rd_data,
  output logic [OW-1:0]           result,
  output logic                    res_valid
);
  logic signed [OW-1:0] acc_q;
  logic signed [OW-1:0] slice_sum;

  // Weight a partial sum by its bit position; the sign slice counts negative.
  function automatic logic signed [OW-1:0] weigh(
    input logic [LW-1:0] part, input int unsigned pos);
    logic signed [OW-1:0] ext;
    ext = OW'($signed(part));
    ext = ext <<< pos;
    return (pos == SW - 1) ? -ext : ext;
  endfunction

  always_comb begin
    slice_sum = '0;
    for (int j = 0; j < BPC; j++)
      slice_sum = slice_sum + weigh(rd_data[j], int'(step) * BPC + j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      result    <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (run) begin
        if (last) begin
          result    <= acc_q + slice_sum;
          res_valid <= 1'b1;
          acc_q     <= '0;
        end else begin
          acc_q <= acc_q + slice_sum;
        end
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(result)); // R3
endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int SW   = 8,
  parameter int CW   = 8,
  parameter int BPC  = 1,
  localparam int LW    = CW + $clog2(TAPS),
  localparam int OW    = LW + SW,
  localparam int TIW   = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int STEPS = SW / BPC,
  localparam int SBW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [SW-1:0]  in_sample,
  input  logic           coef_wr,
  input  logic [TIW-1:0] coef_idx,
  input  logic [CW-1:0]  coef_val,
  output logic           busy,
  output logic           out_valid,
  output logic [OW-1:0]  out_result
);
  ctl_state_e state_q;
  logic [SBW-1:0] step_q;
  logic sample_take, coef_take, last_step, running, rebuild_busy;
  logic [BPC-1:0][TAPS-1:0] slice_addr;
  logic [BPC-1:0][LW-1:0]   slice_part;

  assign running     = (state_q == CTL_RUN);
  assign coef_take   = coef_wr && !running;
  assign sample_take = in_valid && !running && !rebuild_busy && !coef_wr;
  assign last_step   = running && (step_q == SBW'(STEPS - 1));
  assign busy        = running || rebuild_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      step_q  <= '0;
    end else if (running) begin
      step_q <= step_q + 1'b1;
      if (last_step) begin
        state_q <= CTL_IDLE;
        step_q  <= '0;
      end
    end else if (sample_take) begin
      state_q <= CTL_RUN;
      step_q  <= '0;
    end
  end

  dafir_taps #(.TAPS(TAPS), .SW(SW), .BPC(BPC)) u_taps (
    .clk(clk), .rst_n(rst_n), .shift_en(sample_take), .sample_in(in_sample),
    .step(step_q), .slice_addr(slice_addr));

  dafir_lut #(.TAPS(TAPS), .CW(CW), .BPC(BPC)) u_lut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_take), .coef_sel(coef_idx),
    .coef_data(coef_val), .rd_addr(slice_addr), .rd_data(slice_part),
    .rebuild_busy(rebuild_busy));

  dafir_accum #(.TAPS(TAPS), .CW(CW), .SW(SW), .BPC(BPC)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(running), .last(last_step), .step(step_q),
    .rd_data(slice_part), .result(out_result), .res_valid(out_valid));

  AST_EXCLUSIVE_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && rebuild_busy)); // R11
  AST_QUIET_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
    rebuild_busy |-> !out_valid); // R6
  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_take |=> (busy && !out_valid)); // R11
  AST_VALID_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(running)); // R3
endmodule

// File: tb/dafir_top_test.sv
`timescale 1ns/1ps
module dafir_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, coef_wr = 1'b0;
  logic [7:0] in_sample = '0, coef_val = '0;
  logic [1:0] coef_idx = '0;
  logic busy, out_valid;
  logic [17:0] out_result;

  always #2 clk = ~clk;

  dafir_top uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .coef_wr(coef_wr), .coef_idx(coef_idx), .coef_val(coef_val), .busy(busy),
    .out_valid(out_valid), .out_result(out_result));

  int checks = 0, failures = 0;
  int hist[4], coef[4];
  int mode = 0, cnt = 0;    // 0 idle, 1 computing, 2 rebuilding
  int pend = 0, held = 0;
  bit exp_valid = 0;
  string cur_req = "R1";
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dot();
    int s = 0;
    for (int k = 0; k < 4; k++) s += coef[k] * hist[k];
    return s;
  endfunction

  task automatic model(input bit iv, input int smp, input bit cw, input int ci, input int cv);
    exp_valid = 0;
    if (mode == 1) begin
      cnt++;
      if (cnt == 8) begin exp_valid = 1; held = pend; mode = 0; end
    end else if (mode == 2) begin
      if (cw) begin coef[ci] = cv; cnt = 0; end
      else begin cnt++; if (cnt == 16) mode = 0; end
    end else if (cw) begin
      coef[ci] = cv; mode = 2; cnt = 0;
    end else if (iv) begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = smp; pend = dot(); mode = 1; cnt = 0;
    end
  endtask

  task automatic compare();
    check(busy == (mode != 0), "R11", "busy", busy, mode != 0);
    check(out_valid == exp_valid, (mode == 2) ? "R6" : "R3", "out_valid", out_valid, exp_valid);
    check($signed(out_result) == held, exp_valid ? cur_req : "R3", "out_result",
          $signed(out_result), held);
  endtask

  task automatic step(input bit iv, input int smp, input bit cw, input int ci, input int cv);
    in_valid = iv; in_sample = smp[7:0]; coef_wr = cw; coef_idx = ci[1:0]; coef_val = cv[7:0];
    @(posedge clk);
    model(iv, smp, cw, ci, cv);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic load(input int ci, input int cv);
    step(0, 0, 1, ci, cv); idle(17);
  endtask

  task automatic feed(input int smp);
    step(1, smp, 0, 0, 0); idle(9);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin hist[k] = 0; coef[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(out_result == 0, "R1", "out_result after reset", out_result, 0);
    cur_req = "R1"; feed(55);
    // R8: back-to-back writes restart the rebuild; R6 settles it
    cur_req = "R8";
    step(0, 0, 1, 0, 3); step(0, 0, 1, 1, -5); step(0, 0, 1, 2, 7); step(0, 0, 1, 3, 1);
    idle(18);
    cur_req = "R2";
    feed(10); feed(-20); feed(30); feed(127); feed(-1); feed(0); feed(64);
    // R5: in_valid held high through busy periods
    cur_req = "R5";
    for (int i = 0; i < 40; i++) step(1, i * 5 - 100, 0, 0, 0);
    idle(10);
    // R4: extremes
    cur_req = "R6";
    load(0, -128); load(1, -128); load(2, -128); load(3, -128);
    cur_req = "R4";
    feed(-128); feed(-128); feed(-128); feed(-128);
    load(1, 127); load(3, 127);
    cur_req = "R4";
    feed(127); feed(-128); feed(-128); feed(127);
    // R7: write during computation is ignored
    cur_req = "R7";
    step(1, 50, 0, 0, 0); idle(2); step(0, 0, 1, 0, 99); idle(8);
    feed(-7); feed(13);
    // R9: simultaneous write and sample
    cur_req = "R9";
    step(1, 77, 1, 1, -3); idle(18); feed(22);
    // R10: reload mid-stream keeps history
    cur_req = "R10";
    feed(5); feed(-6); feed(7);
    load(2, 100);
    feed(-9); feed(11);
    // mixed pseudo-random stream
    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 1103515245 + 12345;
      step((seed[20:19] != 0), int'($signed(seed[15:8])), (seed[30:24] == 0),
           int'(seed[3:2]), int'($signed(seed[27:20])));
    end
    idle(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule